// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is one timer channel that sits on a simple word-addressed register bus. Software places a start value in the load register, which also primes the counter, and then turns the channel on through the control register. While enabled, the counter steps down once for each pulse on the tick enable that the control register selects. The fast and slow tick enables are generated elsewhere.

When a tick arrives while the counter already reads zero, the channel records an underflow. It raises a level interrupt that stays high until software writes to the clear register. Within the same step, the counter either refills from the load register (periodic mode) or rolls over to all ones and keeps going (free-running mode). The counter width is a parameter, so the same code serves 16-bit and 32-bit channels.

Top module: `itmr_channel`

## Requirements
- R1: After reset the counter, the load register and the control register read zero, and `irq` is low.
- R2: A write to offset 0x0 stores the data as the reload value and copies it into the counter in the same cycle. Both are readable: the reload value at 0x0 and the counter at 0x4.
- R3: While enabled, the counter drops by one on each pulse of the selected tick. Control bit 3 set selects `tick_fast` and clear selects `tick_slow`. Pulses on the other input have no effect.
- R4: While control bit 7 is clear, the counter keeps its value and no underflow occurs, whatever the tick inputs do. Writing 0 to control (offset 0x8) stops the channel.
- R5: With control bit 6 set (periodic), a selected tick at count zero reloads the counter from the reload value.
- R6: With control bit 6 clear (free-running), a selected tick at count zero sets the counter to all ones.
- R7: Every underflow sets `irq`, which then stays high until it is cleared.
- R8: A write of any data to offset 0xC drops `irq`.
- R9: If an underflow and a clear-register write fall in the same cycle, `irq` ends up high.
- R10: Control reads back only bits 7, 6 and 3, with all other bits zero. The clear register reads zero.
- R11: Data bits above the counter width are dropped on a load write and read back as zero. A 16-bit instance wraps to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast tick enable, one cycle per tick |
| tick_slow | input | 1 | Slow tick enable, one cycle per tick |
| bus_sel | input | 1 | Channel selected for an access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the channel (bits 3:2 decoded) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational; zero when no read is selected |
| irq | output | 1 | Sticky underflow interrupt level |

## Verification
Two events can collide in one cycle: an underflow setting the interrupt, and a software write to the clear register dropping it. The bench brings the counter to zero in free-running mode. It then asserts the fast tick and the clear write on the same bus cycle. It expects `irq` to stay high and the counter to read all ones. A later clear on its own must then drop `irq`. The checker also covers the priority cycle by cycle. It requires `irq` high after any underflow, and requires it to fall only when a clear arrives with no underflow in that cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    SLOT_LOAD  = 2'd0,
    SLOT_VALUE = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_CLEAR = 2'd3
  } slot_e;

  localparam int BIT_EN       = 7;
  localparam int BIT_PERIODIC = 6;
  localparam int BIT_FAST     = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.en       = w[BIT_EN];
    c.periodic = w[BIT_PERIODIC];
    c.fast     = w[BIT_FAST];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_EN]       = c.en;
    w[BIT_PERIODIC] = c.periodic;
    w[BIT_FAST]     = c.fast;
    return w;
  endfunction
endpackage

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output logic              load_wr,
  output logic              clr_wr,
  output logic [BUS_W-1:0]  bus_rdata
);
  slot_e slot;
  logic  wr_hit;
  logic  rd_hit;
  logic  ctrl_wr;

  assign slot    = slot_e'(bus_addr[3:2]);
  assign wr_hit  = bus_sel && bus_wr;
  assign rd_hit  = bus_sel && !bus_wr;
  assign load_wr = wr_hit && (slot == SLOT_LOAD);
  assign ctrl_wr = wr_hit && (slot == SLOT_CTRL);
  assign clr_wr  = wr_hit && (slot == SLOT_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= bus_wdata[CNT_W-1:0];
      if (ctrl_wr) ctrl_q <= ctrl_from_word(32'(bus_wdata));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      unique case (slot)
        SLOT_LOAD:  bus_rdata = BUS_W'(load_q);
        SLOT_VALUE: bus_rdata = BUS_W'(cnt_q);
        SLOT_CTRL:  bus_rdata = BUS_W'(ctrl_to_word(ctrl_q));
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/itmr_tick_sel.sv
module itmr_tick_sel (
  input  logic en,
  input  logic use_fast,
  input  logic tick_fast,
  input  logic tick_slow,
  output logic tick_live
);
  logic picked;
  assign picked    = use_fast ? tick_fast : tick_slow;
  assign tick_live = en && picked;
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_live,
  input  logic             periodic,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             underflow
);
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rl,
    input logic             per
  );
    if (cur == '0) return per ? rl : '1;
    return cur - 1'b1;
  endfunction

  assign underflow = tick_live && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load_wr)   cnt_q <= load_val;
    else if (tick_live) cnt_q <= step_count(cnt_q, reload_val, periodic);
  end
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (set_ev) irq_q <= 1'b1;
    else if (clr_ev) irq_q <= 1'b0;
  end
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             load_wr;
  logic             clr_wr;
  logic             tick_live;
  logic             underflow;

  itmr_regfile #(.BUS_W(BUS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
    .load_q(load_q), .ctrl_q(ctrl_q), .load_wr(load_wr), .clr_wr(clr_wr),
    .bus_rdata(bus_rdata)
  );

  itmr_tick_sel u_tick (
    .en(ctrl_q.en), .use_fast(ctrl_q.fast), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .tick_live(tick_live)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_live(tick_live),
    .periodic(ctrl_q.periodic), .load_wr(load_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(load_q),
    .cnt_q(cnt_q), .underflow(underflow)
  );

  itmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(underflow), .clr_ev(clr_wr),
    .irq_q(irq)
  );
endmodule

// File: rtl/itmr_channel_chk.sv
module itmr_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             periodic,
  input logic             tick_live,
  input logic             underflow,
  input logic             load_wr,
  input logic             clr_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] load_q,
  input logic             irq
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_wr) |=> $stable(cnt_q)); // R4
  AST_NO_UNDERFLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !underflow); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_live && cnt_q != '0 && !load_wr) |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && periodic && !load_wr) |=> cnt_q == $past(load_q)); // R5
  AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !periodic && !load_wr) |=> (&cnt_q)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !underflow) |=> !irq); // R8
endmodule

bind itmr_channel itmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .periodic(ctrl_q.periodic),
  .tick_live(tick_live), .underflow(underflow), .load_wr(load_wr),
  .clr_wr(clr_wr), .cnt_q(cnt_q), .load_q(load_q), .irq(irq)
);

// File: tb/tb_itmr_channel.sv
module tb_itmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tf = 1'b0, ts = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata16;
  logic        irq, irq16;
  int          checks = 0, errors = 0;
  logic [31:0] v, v16;

  always #5 clk = ~clk;

  itmr_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tf), .tick_slow(ts),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq)
  );

  itmr_channel #(.CNT_W(16)) dut16 (
    .clk(clk), .rst_n(rst_n), .tick_fast(tf), .tick_slow(ts),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata16), .irq(irq16)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d, output logic [31:0] d16);
    sel = 1; wr = 0; addr = a; #1;
    d = rdata; d16 = rdata16; sel = 0;
  endtask

  task automatic pulse(input bit fast);
    @(negedge clk); if (fast) tf = 1; else ts = 1;
    @(negedge clk); tf = 0; ts = 0;
  endtask

  task automatic t_reset;
    peek(4'h4, v, v16); chk("R1 value", v, 0);
    peek(4'h0, v, v16); chk("R1 load", v, 0);
    peek(4'h8, v, v16); chk("R1 ctrl", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_load;
    bus_write(4'h0, 32'h0001_0010);
    peek(4'h4, v, v16); chk("R2 value", v, 32'h0001_0010);
    chk("R11 value16 truncated", v16, 32'h0010);
    peek(4'h0, v, v16); chk("R2 load", v, 32'h0001_0010);
    bus_write(4'h0, 32'h10);
    peek(4'h4, v, v16); chk("R2 reload value", v, 32'h10);
  endtask

  task automatic t_tick_select;
    bus_write(4'h8, 32'hFFFF_FFFF);
    peek(4'h8, v, v16); chk("R10 ctrl readback", v, 32'hC8);
    repeat (3) pulse(1);
    peek(4'h4, v, v16); chk("R3 fast ticks", v, 32'h0D);
    repeat (2) pulse(0);
    peek(4'h4, v, v16); chk("R3 slow ignored", v, 32'h0D);
    bus_write(4'h8, 32'hC0);
    pulse(0);
    peek(4'h4, v, v16); chk("R3 slow tick", v, 32'h0C);
    pulse(1);
    peek(4'h4, v, v16); chk("R3 fast ignored", v, 32'h0C);
  endtask

  task automatic t_disabled;
    bus_write(4'h8, 32'h0);
    pulse(1); pulse(0);
    peek(4'h4, v, v16); chk("R4 held", v, 32'h0C);
    chk("R4 no irq", irq, 0);
  endtask

  task automatic t_periodic;
    bus_write(4'h0, 32'h2);
    bus_write(4'h8, 32'hC8);
    pulse(1); pulse(1);
    peek(4'h4, v, v16); chk("R3 reach zero", v, 0);
    chk("R7 no irq before underflow", irq, 0);
    pulse(1);
    peek(4'h4, v, v16); chk("R5 reload", v, 32'h2);
    chk("R7 irq set", irq, 1);
    pulse(1);
    peek(4'h4, v, v16); chk("R5 counts after reload", v, 32'h1);
    chk("R7 irq sticky", irq, 1);
  endtask

  task automatic t_clear;
    bus_write(4'hC, 32'hDEAD_BEEF);
    chk("R8 irq cleared", irq, 0);
    peek(4'hC, v, v16); chk("R10 clear reads zero", v, 0);
  endtask

  task automatic t_freerun;
    bus_write(4'h0, 32'h1);
    bus_write(4'h8, 32'h88);
    pulse(1);
    pulse(1);
    peek(4'h4, v, v16); chk("R6 wrap ones", v, 32'hFFFF_FFFF);
    chk("R11 wrap 16-bit", v16, 32'h0000_FFFF);
    chk("R7 irq free-run", irq, 1);
    bus_write(4'hC, 32'h0);
    chk("R8 clear with zero data", irq, 0);
  endtask

  task automatic t_collision;
    bus_write(4'h0, 32'h1);
    pulse(1);
    peek(4'h4, v, v16); chk("R9 at zero", v, 0);
    @(negedge clk); sel = 1; wr = 1; addr = 4'hC; wdata = 32'h5; tf = 1;
    @(negedge clk); sel = 0; wr = 0; tf = 0;
    chk("R9 set wins", irq, 1);
    peek(4'h4, v, v16); chk("R9 wrapped", v, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'h1);
    chk("R8 later clear", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_load;
    t_tick_select;
    t_disabled;
    t_periodic;
    t_clear;
    t_freerun;
    t_collision;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule